// File: doc/BRIEF.md
# Per-Pin Programmable Interrupt Detector

This block monitors a bank of asynchronous input pins and raises interrupts on conditions chosen per pin. Each pin passes through a synchronizer. A per-pin detector compares the synchronized level with the level one clock earlier. Depending on the pin's 4-bit mode code, the detector looks for a low level, a high level, a rising edge, a falling edge or either edge, or it stays idle. A detection sets that pin's flag in a shared status word. The flag stays set until software writes a one to its bit. A single request line is active whenever any flag is set.

Software reaches the block through a plain 32-bit register port. It has one write strobe, a byte address and write data. Read data is registered and follows the address one clock later. There is one control word per pin, with the mode field at bits 19:16, and one status word at a fixed address.

Top module: `pin_irq_detector`

## Requirements
- R1: The control word of pin n is at byte address 4*n, for n from 0 to NUM_PINS-1. Its mode code is written from and read back at bits 19:16, and all other bits read as zero.
- R2: Mode code 0x0 and every code other than 0x8, 0x9, 0xA, 0xB and 0xC never set the pin's flag, whatever the pin does.
- R3: Mode 0x8 sets the flag on every clock in which the synchronized pin is 0.
- R4: Mode 0xC sets the flag on every clock in which the synchronized pin is 1.
- R5: Mode 0x9 sets the flag only when the synchronized pin goes from 0 to 1. A steady high level or a falling edge sets nothing.
- R6: Mode 0xA sets the flag only when the synchronized pin goes from 1 to 0.
- R7: Mode 0xB sets the flag on either transition of the synchronized pin.
- R8: The status word is at byte address 0xA0, with bit n holding the flag of pin n. Writing 1 to a bit clears that flag. Writing 0 leaves it unchanged. Flags are sticky otherwise.
- R9: In the same clock, a detection takes priority over a clear of that bit. So a level that is still present re-sets its flag at once.
- R10: `irq_o` is high exactly when at least one flag is set, in the same clock as the flags.
- R11: After reset, all mode codes, flags, `irq_o` and `bus_rdata` are zero.
- R12: The pins pass two synchronizer flops. A pin change sampled at clock edge k reaches the status flags, and `irq_o`, at edge k+2.
- R13: `bus_rdata` shows the word addressed in the previous clock. Unaligned or unmapped addresses read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | NUM_PINS | Asynchronous monitored pins |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous clock's address |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A change on a pin that the first synchronizer flop captures at edge k reaches the flags and `irq_o` at edge k+2. Read data reflects the flags one edge after that. Register reads are due one edge after the address is driven.

The bench drives all inputs on falling edges. It advances a behavioural model on each rising edge and compares `irq_o` and `bus_rdata` on every falling edge, so each result is checked in the clock where it becomes due. Directed checks wait at least four clocks after a pin change before reading status. The one exception is the latency check, which samples `irq_o` after exactly two and then three edges.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  typedef enum logic [3:0] {
    MODE_OFF  = 4'h0,
    MODE_LOW  = 4'h8,
    MODE_RISE = 4'h9,
    MODE_FALL = 4'hA,
    MODE_BOTH = 4'hB,
    MODE_HIGH = 4'hC
  } pin_mode_e;

  localparam int MODE_W      = 4;
  localparam int MODE_LSB    = 16;
  localparam int STATUS_WORD = 40;  // byte address 0xA0
endpackage

// File: rtl/pirq_sync.sv
module pirq_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pirq_cond.sv
module pirq_cond
  import pirq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_PINS-1:0]        cur_i,
  input  logic [NUM_PINS*MODE_W-1:0] mode_i,
  output logic [NUM_PINS-1:0]        hit_o
);
  logic [NUM_PINS-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= cur_i;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [MODE_W-1:0] m;
    assign m = mode_i[i*MODE_W +: MODE_W];
    always_comb begin
      case (m)
        MODE_LOW:  hit_o[i] = ~cur_i[i];
        MODE_HIGH: hit_o[i] = cur_i[i];
        MODE_RISE: hit_o[i] = cur_i[i] & ~prev_q[i];
        MODE_FALL: hit_o[i] = ~cur_i[i] & prev_q[i];
        MODE_BOTH: hit_o[i] = cur_i[i] ^ prev_q[i];
        default:   hit_o[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/pirq_modes.sv
module pirq_modes
  import pirq_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int IDX_W    = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [MODE_W-1:0]          wr_mode,
  output logic [NUM_PINS*MODE_W-1:0] mode_o
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_mode
    logic [MODE_W-1:0] mode_q;
    always_ff @(posedge clk) begin
      if (rst)                                 mode_q <= '0;
      else if (wr_en && wr_idx == IDX_W'(i))   mode_q <= wr_mode;
    end
    assign mode_o[i*MODE_W +: MODE_W] = mode_q;
  end
endmodule

// File: rtl/pin_irq_detector.sv
module pin_irq_detector
  import pirq_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                irq_o
);
  localparam int                IDX_W       = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(STATUS_WORD * 4);

  logic [NUM_PINS-1:0]        pins_s, hit, clr, status_q, status_d;
  logic [NUM_PINS*MODE_W-1:0] mode_flat;
  logic [IDX_W-1:0]           word;
  logic                       ctrl_sel, sts_sel;
  logic [31:0]                rd_mux;
  logic                       irq_q;
  logic [31:0]                rdata_q;

  assign word     = bus_addr[ADDR_W-1:2];
  assign ctrl_sel = (bus_addr[1:0] == 2'b00) && (int'(word) < NUM_PINS);
  assign sts_sel  = (bus_addr == STATUS_ADDR);

  pirq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(pins_i), .q_o(pins_s)
  );

  pirq_modes #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_modes (
    .clk(clk), .rst(rst),
    .wr_en(bus_wr && ctrl_sel),
    .wr_idx(word),
    .wr_mode(bus_wdata[MODE_LSB +: MODE_W]),
    .mode_o(mode_flat)
  );

  pirq_cond #(.NUM_PINS(NUM_PINS)) u_cond (
    .clk(clk), .rst(rst), .cur_i(pins_s), .mode_i(mode_flat), .hit_o(hit)
  );

  // Detection is OR-ed in after the clear, so it wins a same-cycle race.
  assign clr      = (bus_wr && sts_sel) ? bus_wdata[NUM_PINS-1:0] : '0;
  assign status_d = (status_q & ~clr) | hit;

  always_comb begin
    rd_mux = '0;
    if (sts_sel) rd_mux[NUM_PINS-1:0] = status_q;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (ctrl_sel && int'(word) == i)
        rd_mux[MODE_LSB +: MODE_W] = mode_flat[i*MODE_W +: MODE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      irq_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      status_q <= status_d;
      irq_q    <= |status_d;
      rdata_q  <= rd_mux;
    end
  end

  assign irq_o     = irq_q;
  assign bus_rdata = rdata_q;
endmodule

// File: rtl/pirq_checker.sv
module pirq_checker
  import pirq_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       bus_wr,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [31:0]                bus_wdata,
  input logic [NUM_PINS-1:0]        status_q,
  input logic [NUM_PINS-1:0]        hit,
  input logic [NUM_PINS*MODE_W-1:0] mode_flat,
  input logic                       irq_o
);
  localparam logic [ADDR_W-1:0] STS = ADDR_W'(STATUS_WORD * 4);

  logic                sts_wr;
  logic [NUM_PINS-1:0] wmask;
  assign sts_wr = bus_wr && (bus_addr == STS);
  assign wmask  = bus_wdata[NUM_PINS-1:0];

  // R11
  a_r11_reset_clear: assert property (@(posedge clk)
    rst |=> (status_q == '0 && !irq_o));

  // R10
  a_r10_irq_or: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|status_q));

  // R8: without a clear write, no flag drops
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    !sts_wr |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R8: a written one clears the bit unless a detection coincides
  a_r8_w1c: assert property (@(posedge clk) disable iff (rst)
    sts_wr |=> ((status_q & $past(wmask) & ~$past(hit)) == '0));

  // R9: detection beats a same-cycle clear
  a_r9_detect_wins: assert property (@(posedge clk) disable iff (rst)
    (sts_wr && (wmask & hit) != '0) |=>
      ((status_q & $past(wmask & hit)) == $past(wmask & hit)));

  // R2: undefined or off codes never detect
  always @(posedge clk) begin
    if (!rst) begin
      for (int i = 0; i < NUM_PINS; i++) begin
        logic [3:0] m;
        m = mode_flat[i*MODE_W +: MODE_W];
        if (!(m inside {4'h8, 4'h9, 4'hA, 4'hB, 4'hC}))
          a_r2_off_no_hit: assert (!hit[i]);
      end
    end
  end
endmodule

bind pin_irq_detector pirq_checker #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .status_q(status_q), .hit(hit),
  .mode_flat(mode_flat), .irq_o(irq_o)
);

// File: tb/sim_pin_irq_detector.sv
`timescale 1ns/1ps
module sim_pin_irq_detector;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pins = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #10 clk = ~clk;  // 50 MHz

  pin_irq_detector u0 (
    .clk(clk), .rst(rst), .pins_i(pins), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // Behavioural reference model
  logic [31:0] m_s1, m_s2, m_prev, m_status, m_rdata;
  logic        m_irq;
  int          m_mode [32];

  always @(posedge clk) begin
    logic [31:0] hitv, clrv;
    int          idx;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_status = 0; m_rdata = 0; m_irq = 0;
      for (int i = 0; i < 32; i++) m_mode[i] = 0;
    end else begin
      hitv = 0;
      for (int i = 0; i < 32; i++) begin
        case (m_mode[i])
          8:  hitv[i] = !m_s2[i];
          12: hitv[i] = m_s2[i];
          9:  hitv[i] = m_s2[i] && !m_prev[i];
          10: hitv[i] = !m_s2[i] && m_prev[i];
          11: hitv[i] = m_s2[i] != m_prev[i];
          default: hitv[i] = 0;
        endcase
      end
      clrv = (bus_wr && bus_addr == 8'hA0) ? bus_wdata : 32'h0;
      idx  = int'(bus_addr) / 4;
      if (bus_addr[1:0] == 2'b00 && bus_addr < 8'h80) m_rdata = 32'(m_mode[idx]) << 16;
      else if (bus_addr == 8'hA0)                      m_rdata = m_status;
      else                                             m_rdata = 0;
      m_status = (m_status & ~clrv) | hitv;
      m_irq    = (m_status != 0);
      if (bus_wr && bus_addr[1:0] == 2'b00 && bus_addr < 8'h80)
        m_mode[idx] = int'(bus_wdata[19:16]);
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pins;
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Every-clock comparison against the model (R10, R13)
  always @(negedge clk) begin
    if (!rst) begin
      check({31'h0, irq_o}, {31'h0, m_irq}, "R10 irq_o vs model");
      check(bus_rdata, m_rdata, "R13 bus_rdata vs model");
    end
  end

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<50000", cyc);
      finish_run();
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    @(negedge clk);
    check(bus_rdata, exp, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    idle(2);
    // R11 reset state
    check({31'h0, irq_o}, 32'h0, "R11 irq after reset");
    rd_chk(8'hA0, 32'h0, "R11 status after reset");
    rd_chk(8'h0C, 32'h0, "R11 control after reset");

    // R1 readback, R2 undefined code
    wr(8'h0C, 32'hFFFF_FFFF);
    rd_chk(8'h0C, 32'h000F_0000, "R1 control field readback");
    pins[3] = 1'b1; idle(4); pins[3] = 1'b0; idle(4);
    rd_chk(8'hA0, 32'h0, "R2 code 0xF detects nothing");

    // R3 low level
    wr(8'h00, 32'h0008_0000);
    idle(4);
    rd_chk(8'hA0, 32'h1, "R3 low level sets flag");
    check({31'h0, irq_o}, 32'h1, "R10 irq with flag set");

    // R9 clear while level still present
    wr(8'hA0, 32'h1);
    rd_chk(8'hA0, 32'h1, "R9 level re-sets despite clear");
    wr(8'h00, 32'h0);
    wr(8'hA0, 32'hFFFF_FFFF);
    idle(2);
    rd_chk(8'hA0, 32'h0, "R2 mode 0 masks pin, R8 clear");
    check({31'h0, irq_o}, 32'h0, "R10 irq drops");

    // R4 high level, R8 zero write
    wr(8'h04, 32'h000C_0000);
    idle(4);
    rd_chk(8'hA0, 32'h0, "R4 high mode with low pin");
    pins[1] = 1'b1; idle(4);
    rd_chk(8'hA0, 32'h2, "R4 high level sets flag");
    wr(8'hA0, 32'h0);
    rd_chk(8'hA0, 32'h2, "R8 writing zero keeps flag");
    wr(8'h04, 32'h0);
    wr(8'hA0, 32'h2);
    idle(1);
    rd_chk(8'hA0, 32'h0, "R8 write one clears");

    // R5 rising
    wr(8'h08, 32'h0009_0000);
    pins[2] = 1'b1; idle(4);
    rd_chk(8'hA0, 32'h4, "R5 rising sets flag");
    wr(8'hA0, 32'h4); idle(4);
    rd_chk(8'hA0, 32'h0, "R5 steady high no re-set");
    pins[2] = 1'b0; idle(4);
    rd_chk(8'hA0, 32'h0, "R5 falling ignored");

    // R6 falling
    wr(8'h10, 32'h000A_0000);
    pins[4] = 1'b1; idle(4);
    rd_chk(8'hA0, 32'h0, "R6 rising ignored");
    pins[4] = 1'b0; idle(4);
    rd_chk(8'hA0, 32'h10, "R6 falling sets flag");
    wr(8'hA0, 32'h10);

    // R7 either edge
    wr(8'h14, 32'h000B_0000);
    pins[5] = 1'b1; idle(4);
    rd_chk(8'hA0, 32'h20, "R7 rise sets flag");
    wr(8'hA0, 32'h20); idle(2);
    rd_chk(8'hA0, 32'h0, "R7 cleared");
    pins[5] = 1'b0; idle(4);
    rd_chk(8'hA0, 32'h20, "R7 fall sets flag");
    wr(8'hA0, 32'h20);

    // R1 last pin at 0x7C
    wr(8'h7C, 32'h000C_0000);
    pins[31] = 1'b1; idle(4);
    rd_chk(8'hA0, 32'h8000_0000, "R1 pin 31 control at 0x7C");
    rd_chk(8'h7C, 32'h000C_0000, "R1 pin 31 readback");
    wr(8'h7C, 32'h0);
    wr(8'hA0, 32'hFFFF_FFFF);

    // R13 unmapped and unaligned
    wr(8'h80, 32'hFFFF_FFFF);
    wr(8'h01, 32'h000C_0000);
    wr(8'hA4, 32'hFFFF_FFFF);
    rd_chk(8'h80, 32'h0, "R13 unmapped reads zero");
    rd_chk(8'h00, 32'h0, "R13 unaligned write ignored");
    rd_chk(8'hA0, 32'h0, "R13 unmapped write no effect");

    // R12 latency
    wr(8'h18, 32'h0009_0000);
    idle(3);
    pins[6] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check({31'h0, irq_o}, 32'h0, "R12 not yet after two edges");
    @(negedge clk);
    check({31'h0, irq_o}, 32'h1, "R12 irq after three edges");
    wr(8'hA0, 32'hFFFF_FFFF);
    idle(3);
    finish_run();
  end
endmodule